// File: doc/BRIEF.md
# SPI Low-Power Mode Controller

This block governs the power modes of a queued SPI peripheral. It owns the small transmit and receive FIFOs, the control, status and interrupt-enable registers on a simple register bus, and the clock-enable output that gates the serial engine. The serial engine is outside the block. It reports whether a frame is running and when a frame finishes, and it pulls transmit data and pushes received data through a narrow engine-side port.

Two low-power paths exist. A system power manager can raise an external stop request. The block acknowledges it at once and reports ready for clock shutdown only once any running frame has completed. While stopped, the register bus reads as zero, accepts no writes, and the interrupt and DMA request outputs are frozen. The second path is module disable, entered through a software bit or through a doze input that is qualified by an enable bit. Disable entry also waits for a frame boundary before clock enable drops. While disabled, every register still reads back correctly, but accesses that would change state are dropped without effect.

Top module: `spi_pwr_ctl`

## Requirements
- R1: After reset, clk_en is high; stop_ack, stop_rdy, irq and dma_req are low; both FIFO levels read zero.
- R2: A write to address 1 pushes a TX entry. The oldest TX entry appears on eng_tx_data and eng_tx_pop removes it. eng_rx_push stores eng_rx_data. A read of address 2 returns the oldest RX entry and removes it. Address 6 reads the TX level in bits [3:0] and the RX level in bits [7:4]. CTRL (address 0) bit 4 empties the TX FIFO and bit 5 empties the RX FIFO.
- R3: The disable condition is CTRL bit 0 set, or the doze input high while CTRL bit 1 is set. Doze with CTRL bit 1 clear has no effect.
- R4: When the disable condition arises while frame_active is high, clk_en stays high until the edge at which frame_end is seen and drops after that edge. With no frame running, clk_en drops after the next edge.
- R5: While disabled, all registers read correctly. STAT (address 3) has bit 0 frame-done, bit 1 RX overflow, bit 2 RX not empty, bit 3 TX full and bit 4 disabled. A read of address 2 returns the RX head without removing it.
- R6: While disabled, TX pushes, the FIFO clear bits (CTRL bits 4 and 5), changes to the FIFO-off bits (CTRL bits 2 and 3) and engine pops are all ignored.
- R7: While disabled, write-one-to-clear of STAT, writes to the frame count (address 5) and writes to the interrupt enables (address 4) are ignored, so asserted irq and dma_req stay asserted.
- R8: Once CTRL bit 0 is clear and the doze condition is false, clk_en is high after the next edge. FIFO contents are preserved, and push and pop work again.
- R9: stop_ack is high one cycle after stop_req. stop_rdy rises after the frame boundary, or after the next edge when no frame is running. When stop_req is withdrawn, both outputs are low after the next edge and clk_en is high again.
- R10: While stop_rdy is high, clk_en is low, bus reads return zero, bus writes are ignored, and irq and dma_req hold their values.
- R11: A stop request that arrives together with a disable condition enters stop. When the stop request is withdrawn while the disable condition still holds, the block goes straight to disabled with clk_en kept low.
- R12: frame_end increments the frame count and sets frame-done. irq = (frame-done and address-4 bit 0) or (overflow and bit 1), and dma_req = RX not empty and bit 2. Both outputs are registered one cycle after their source changes.
- R13: With CTRL bit 2 set, bus pushes to TX are dropped. With CTRL bit 3 set, engine RX pushes are dropped. An RX push into a full FIFO is discarded and sets overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| frame_active | input | 1 | Engine frame in progress |
| frame_end | input | 1 | Engine frame boundary pulse |
| eng_tx_pop | input | 1 | Engine takes TX head |
| eng_tx_data | output | DW | TX FIFO head |
| eng_rx_push | input | 1 | Engine delivers an RX word |
| eng_rx_data | input | DW | Received word |
| stop_req | input | 1 | External stop request |
| stop_ack | output | 1 | Stop request acknowledge |
| stop_rdy | output | 1 | Ready for clock shutdown |
| doze | input | 1 | Doze request from power manager |
| clk_en | output | 1 | Clock enable for non-register logic |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 3-bit address and a FIFO depth of 4. A depth of 4 lets a handful of engine pushes fill the RX FIFO and reach the overflow path. The 8-bit width leaves room for both 3-bit levels in the level register. The frame boundary is driven directly, so entry into disable and into stop can be placed both mid-frame and between frames, and the one-cycle output latencies can be checked at exact edges.

// File: rtl/spi_pwr_ctl.sv
module spi_pwr_ctl #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          frame_active,
  input  logic          frame_end,
  input  logic          eng_tx_pop,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_rx_push,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          stop_req,
  output logic          stop_ack,
  output logic          stop_rdy,
  input  logic          doze,
  output logic          clk_en,
  output logic          irq,
  output logic          dma_req
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TXD  = AW'(1);
  localparam logic [AW-1:0] A_RXD  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam logic [AW-1:0] A_XCNT = AW'(5);
  localparam logic [AW-1:0] A_LVL  = AW'(6);

  typedef enum logic [2:0] {M_RUN, M_DPND, M_DIS, M_SPND, M_STOP} mode_t;
  mode_t st, st_nx;

  logic soft_dis, doze_en, tx_off, rx_off;
  logic done_f, ovf_f;
  logic [2:0] ien;
  logic [DW-1:0] xcnt;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic stop_q;

  wire bnd      = ~frame_active | frame_end;
  wire dis_cond = soft_dis | (doze & doze_en);
  wire stopped  = (st == M_STOP);
  wire disabled = (st == M_DIS);
  wire reg_ok   = ~stopped & ~disabled;
  wire eng_ok   = clk_en;
  wire wr       = bus_sel & bus_wr;
  wire rd       = bus_sel & ~bus_wr;
  wire wr_ctrl  = wr & (bus_addr == A_CTRL);

  assign clk_en   = (st == M_RUN) | (st == M_DPND) | (st == M_SPND);
  assign stop_rdy = stopped;
  assign stop_ack = stop_q;

  always_comb begin
    st_nx = st;
    case (st)
      M_RUN, M_DPND:
        if (stop_req)           st_nx = bnd ? M_STOP : M_SPND;
        else if (!dis_cond)     st_nx = M_RUN;
        else                    st_nx = bnd ? M_DIS : M_DPND;
      M_SPND:
        if (!stop_req)          st_nx = M_RUN;
        else if (bnd)           st_nx = M_STOP;
      M_DIS:
        if (stop_req)           st_nx = M_STOP;
        else if (!dis_cond)     st_nx = M_RUN;
      M_STOP:
        if (!stop_req)          st_nx = dis_cond ? M_DIS : M_RUN;
      default:                  st_nx = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= M_RUN;
      stop_q <= 1'b0;
    end else begin
      st     <= st_nx;
      stop_q <= stop_req;
    end

  wire tx_push = wr & (bus_addr == A_TXD) & reg_ok & ~tx_off & (tx_cnt != FULL);
  wire tx_pop  = eng_tx_pop & eng_ok & (tx_cnt != '0);
  wire tx_clr  = wr_ctrl & reg_ok & bus_wdata[4];
  wire rx_in   = eng_rx_push & eng_ok & ~rx_off;
  wire rx_push = rx_in & (rx_cnt != FULL);
  wire rx_lost = rx_in & (rx_cnt == FULL);
  wire rx_pop  = rd & (bus_addr == A_RXD) & reg_ok & (rx_cnt != '0);
  wire rx_clr  = wr_ctrl & reg_ok & bus_wdata[5];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (tx_pop)  tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      soft_dis <= 1'b0; doze_en <= 1'b0; tx_off <= 1'b0; rx_off <= 1'b0;
      ien <= '0; xcnt <= '0; done_f <= 1'b0; ovf_f <= 1'b0;
    end else begin
      if (wr_ctrl & ~stopped) begin
        soft_dis <= bus_wdata[0];
        doze_en  <= bus_wdata[1];
        if (reg_ok) begin
          tx_off <= bus_wdata[2];
          rx_off <= bus_wdata[3];
        end
      end
      if (wr & reg_ok & (bus_addr == A_IEN)) ien <= bus_wdata[2:0];
      if (wr & reg_ok & (bus_addr == A_XCNT)) xcnt <= bus_wdata;
      else if (frame_end & eng_ok)            xcnt <= xcnt + DW'(1);
      if (frame_end & eng_ok)                                  done_f <= 1'b1;
      else if (wr & reg_ok & (bus_addr == A_STAT) & bus_wdata[0]) done_f <= 1'b0;
      if (rx_lost)                                             ovf_f <= 1'b1;
      else if (wr & reg_ok & (bus_addr == A_STAT) & bus_wdata[1]) ovf_f <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq <= 1'b0; dma_req <= 1'b0;
    end else if (!stopped) begin
      irq     <= (done_f & ien[0]) | (ovf_f & ien[1]);
      dma_req <= (rx_cnt != '0) & ien[2];
    end

  assign eng_tx_data = tx_mem[tx_rp];

  always_comb begin
    bus_rdata = '0;
    if (!stopped)
      case (bus_addr)
        A_CTRL: bus_rdata = DW'({rx_off, tx_off, doze_en, soft_dis});
        A_TXD:  bus_rdata = DW'(tx_cnt);
        A_RXD:  bus_rdata = rx_mem[rx_rp];
        A_STAT: bus_rdata = DW'({disabled, tx_cnt == FULL, rx_cnt != '0, ovf_f, done_f});
        A_IEN:  bus_rdata = DW'(ien);
        A_XCNT: bus_rdata = xcnt;
        A_LVL:  bus_rdata = DW'(tx_cnt) | (DW'(rx_cnt) << 4);
        default: bus_rdata = '0;
      endcase
  end

  // R4
  mid_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> $past(~frame_active | frame_end));

  // R6
  dis_fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(disabled) |-> ($stable(tx_cnt) && $stable(rx_cnt)));

  // R9
  rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rdy |-> $past(stop_req));

  // R10
  stop_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_rdy) |-> ($stable(irq) && $stable(dma_req)));

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL) && (rx_cnt <= FULL));

endmodule

// File: tb/test_spi_pwr_ctl.sv
module test_spi_pwr_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, eng_tx_data, eng_rx_data = '0;
  logic frame_active = 0, frame_end = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic stop_req = 0, doze = 0;
  logic stop_ack, stop_rdy, clk_en, irq, dma_req;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  spi_pwr_ctl i_spi_pwr_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_active(frame_active), .frame_end(frame_end),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .stop_req(stop_req), .stop_ack(stop_ack), .stop_rdy(stop_rdy),
    .doze(doze), .clk_en(clk_en), .irq(irq), .dma_req(dma_req));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    tick();
    bus_sel = 0;
  endtask

  task automatic rxp(input logic [7:0] d);
    eng_rx_push = 1; eng_rx_data = d;
    tick();
    eng_rx_push = 0;
  endtask

  task automatic frame(input int len);
    frame_active = 1;
    repeat (len) tick();
    frame_end = 1; tick();
    frame_active = 0; frame_end = 0;
  endtask

  task automatic t_reset();
    chk("R1 clk_en", clk_en, 1);
    chk("R1 stop_ack", stop_ack, 0);
    chk("R1 stop_rdy", stop_rdy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
    rd(6, v); chk("R1 levels", v, 8'h00);
  endtask

  task automatic t_normal();
    wr(1, 8'hA5); wr(1, 8'h3C);
    rd(6, v); chk("R2 tx level", v, 8'h02);
    chk("R2 tx head", eng_tx_data, 8'hA5);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0;
    chk("R2 tx head after pop", eng_tx_data, 8'h3C);
    rxp(8'h11); rxp(8'h22);
    rd(6, v); chk("R2 levels", v, 8'h21);
    rd(2, v); chk("R2 rx first", v, 8'h11);
    rd(6, v); chk("R2 levels after pop", v, 8'h11);
    rd(2, v); chk("R2 rx second", v, 8'h22);
    wr(0, 8'h10);
    rd(6, v); chk("R2 tx clear", v, 8'h00);
    wr(4, 8'h01);
    frame(2);
    chk("R12 irq latency", irq, 0);
    tick(); chk("R12 irq on done", irq, 1);
    rd(5, v); chk("R12 frame count", v, 8'h01);
    rd(3, v); chk("R12 status done", v, 8'h01);
    wr(3, 8'h01); tick(); chk("R12 irq cleared", irq, 0);
    wr(4, 8'h04); rxp(8'h5A); tick();
    chk("R12 dma on rx", dma_req, 1);
    rd(2, v); tick(); chk("R12 dma off", dma_req, 0);
    wr(4, 8'h00);
  endtask

  task automatic t_rxfull();
    for (int i = 0; i < 5; i++) rxp(8'hB0 + 8'(i));
    rd(3, v); chk("R13 overflow flag", v, 8'h06);
    rd(6, v); chk("R13 rx full level", v, 8'h40);
    rd(2, v); chk("R13 oldest kept", v, 8'hB0);
    wr(0, 8'h20); rd(6, v); chk("R2 rx clear", v, 8'h00);
    wr(3, 8'h02); rd(3, v); chk("R13 ovf cleared", v, 8'h00);
    wr(0, 8'h04); wr(1, 8'hEE);
    rd(6, v); chk("R13 tx off drops", v, 8'h00);
    wr(0, 8'h08); rxp(8'hCC);
    rd(6, v); chk("R13 rx off drops", v, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_doze();
    doze = 1; tick();
    chk("R3 doze without enable", clk_en, 1);
    wr(0, 8'h02);
    chk("R4 no frame wait edge", clk_en, 1);
    tick(); chk("R3 doze disables", clk_en, 0);
    rd(3, v); chk("R5 disabled bit", v, 8'h10);
    doze = 0; tick(); chk("R8 doze release", clk_en, 1);
    wr(0, 8'h00);
  endtask

  task automatic t_disabled();
    wr(5, 8'h40); wr(1, 8'h77); wr(1, 8'h88);
    rxp(8'h99); rxp(8'hAA); wr(4, 8'h05);
    frame_active = 1; tick();
    wr(0, 8'h01); tick(); tick();
    chk("R4 held mid frame", clk_en, 1);
    frame_end = 1; tick(); frame_active = 0; frame_end = 0;
    chk("R4 drop at boundary", clk_en, 0);
    tick();
    chk("R7 irq pending", irq, 1);
    chk("R7 dma pending", dma_req, 1);
    rd(6, v); chk("R5 levels readable", v, 8'h22);
    rd(2, v); chk("R5 rx head readable", v, 8'h99);
    rd(6, v); chk("R5 pop ignored", v, 8'h22);
    rd(3, v); chk("R5 status readable", v, 8'h15);
    wr(1, 8'h55); rd(6, v); chk("R6 push ignored", v, 8'h22);
    wr(0, 8'h3D); rd(6, v); chk("R6 clear ignored", v, 8'h22);
    rd(0, v); chk("R6 fifo-off ignored", v, 8'h01);
    wr(3, 8'h01); rd(3, v); chk("R7 w1c ignored", v, 8'h15);
    wr(5, 8'h00); rd(5, v); chk("R7 count write ignored", v, 8'h41);
    wr(4, 8'h00); rd(4, v); chk("R7 ien write ignored", v, 8'h05);
    tick();
    chk("R7 irq held", irq, 1);
    chk("R7 dma held", dma_req, 1);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0;
    chk("R6 engine pop ignored", eng_tx_data, 8'h77);
    wr(0, 8'h00);
    chk("R8 still low before edge", clk_en, 0);
    tick(); chk("R8 clk_en back", clk_en, 1);
    rd(2, v); chk("R8 rx preserved", v, 8'h99);
    rd(6, v); chk("R8 pop resumes", v, 8'h12);
    chk("R8 tx preserved", eng_tx_data, 8'h77);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0;
    chk("R8 engine pop resumes", eng_tx_data, 8'h88);
    wr(0, 8'h30); wr(3, 8'h03); wr(4, 8'h00); tick(); tick();
  endtask

  task automatic t_stop();
    wr(4, 8'h01); frame(1); tick(); tick();
    chk("R12 irq before stop", irq, 1);
    frame_active = 1; stop_req = 1; tick();
    chk("R9 ack next cycle", stop_ack, 1);
    chk("R9 not ready mid frame", stop_rdy, 0);
    tick(); chk("R9 still waiting", stop_rdy, 0);
    frame_end = 1; tick(); frame_active = 0; frame_end = 0;
    chk("R9 ready at boundary", stop_rdy, 1);
    chk("R10 clk_en off", clk_en, 0);
    rd(3, v); chk("R10 reads zero", v, 8'h00);
    wr(3, 8'h01);
    chk("R10 irq held", irq, 1);
    stop_req = 0; tick();
    chk("R9 ready released", stop_rdy, 0);
    chk("R9 ack released", stop_ack, 0);
    chk("R9 clk_en back", clk_en, 1);
    rd(3, v); chk("R10 write ignored", v, 8'h01);
    stop_req = 1; tick();
    chk("R9 ready without frame", stop_rdy, 1);
    stop_req = 0; tick();
    wr(3, 8'h01); wr(4, 8'h00); tick();
  endtask

  task automatic t_prio();
    wr(0, 8'h02);
    doze = 1; stop_req = 1; tick();
    chk("R11 stop wins", stop_rdy, 1);
    chk("R11 clk_en off", clk_en, 0);
    stop_req = 0; tick();
    chk("R11 leaves stop", stop_rdy, 0);
    chk("R11 no clk_en pulse", clk_en, 0);
    rd(3, v); chk("R11 lands disabled", v, 8'h10);
    doze = 0; tick();
    chk("R8 after priority case", clk_en, 1);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tick();
    t_reset();
    t_normal();
    t_rxfull();
    t_doze();
    t_disabled();
    t_stop();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule